// File: doc/BRIEF.md
# Load-Forwarding Store Buffer

This block holds store operations that a write-through data cache has already applied to its own lines. It keeps them in an eight-slot ring with a head and a tail pointer. It hands them to a byte-serial memory controller only when that controller has no read waiting. Cache misses therefore win the bus, and buffered writes fill the idle gaps between them.

Each entry keeps an 18-bit byte address, 32 bits of data and a 2-bit width code. Size code 2'b00 is a byte, 2'b01 a half-word and 2'b10 a word. The same address may sit in several slots at once. A load lookup compares word addresses (address bits 17:2) against every occupied slot. It answers from the newest matching slot, found by walking backward from the tail. Only a full-word newest match can be forwarded. A narrower newest match is flagged as a conflict, and the load must wait until that entry has drained.

A small state machine governs draining and has two states. DR_IDLE waits. It moves to DR_SEND in a cycle where the ring is non-empty and the read-pending input is low. DR_SEND raises the drain request with the head entry's fields. It stays there until the controller acknowledges. The acknowledge removes the head entry and returns the machine to DR_IDLE.

Top module: `wbuf_write_buffer`

## Requirements
- R1: During and straight after reset, empty is 1, full is 0, st_ready is 1, drn_req is 0, and ld_hit and ld_conflict are 0.
- R2: A store with st_valid high and st_ready high is appended at the tail. st_ready equals the inverse of full. full is 1 exactly when 8 entries are held, and empty is 1 exactly when none are held.
- R3: A store offered while full is dropped and leaves the ring unchanged. The stall is visible as st_ready low.
- R4: Entries drain in arrival order. While drn_req is high, drn_addr, drn_data and drn_size show the oldest entry.
- R5: drn_req rises only after a clock edge at which the ring was non-empty and bus_rd_busy was low (transition DR_IDLE to DR_SEND).
- R6: Once raised, drn_req stays high with stable fields until drn_ack is seen (state DR_SEND held).
- R7: An entry leaves the ring only at an edge where drn_req and drn_ack are both high. drn_ack at any other time has no effect, and drn_req is never high while empty.
- R8: A store accepted in the same cycle as a drain acknowledge is enqueued while the head is removed, so the occupancy is unchanged.
- R9: With ld_valid high, if the newest entry whose address bits 17:2 equal ld_addr bits 17:2 has size code 2'b10, ld_hit is 1 and ld_data is that entry's data.
- R10: If that newest matching entry has size code 2'b00 or 2'b01, ld_conflict is 1, ld_hit is 0 and ld_data is 0, even when an older full-word match exists.
- R11: With no matching entry or with ld_valid low, ld_hit and ld_conflict are 0 and ld_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | 18 | Store byte address |
| st_data | input | 32 | Store data |
| st_size | input | 2 | Store width code (00 byte, 01 half, 10 word) |
| st_ready | output | 1 | Store accepted this cycle when high |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 18 | Load byte address |
| ld_hit | output | 1 | Newest match is a full word; data forwarded |
| ld_conflict | output | 1 | Newest match is partial; load must wait |
| ld_data | output | 32 | Forwarded word |
| bus_rd_busy | input | 1 | Memory controller has a read pending |
| drn_req | output | 1 | Write of head entry requested |
| drn_addr | output | 18 | Head entry address |
| drn_data | output | 32 | Head entry data |
| drn_size | output | 2 | Head entry width code |
| drn_ack | input | 1 | Controller finished the requested write |
| full | output | 1 | Eight entries held |
| empty | output | 1 | No entries held |

## Verification
A store enqueue and a drain acknowledge can land on the same edge. A load lookup can also see an entry in the very cycle that entry is being removed, or one cycle before a younger store for the same word lands. The bench provokes these overlaps by holding the read-pending input low with a high acknowledge rate while stores arrive on most cycles. Addresses come from a pool of four words, so duplicates and partial overlaps are frequent. A queue-based reference model predicts full, empty, the drain fields and every lookup result on each clock, and counts how often enqueue and acknowledge coincided.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 32;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [1:0]        size;
    } wb_entry_t;

    typedef enum logic {
        DR_IDLE,
        DR_SEND
    } drain_st_e;
endpackage

// File: rtl/wbuf_ring.sv
module wbuf_ring
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  wb_entry_t             push_ent,
    input  logic                  pop,
    output wb_entry_t [DEPTH-1:0] slots,
    output logic [PW-1:0]         tail,
    output logic [CW-1:0]         cnt,
    output wb_entry_t             head_ent
);
    logic [PW-1:0] head;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                slots[tail] <= push_ent;
                tail        <= nxt(tail);
            end
            if (pop) begin
                head <= nxt(head);
            end
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head_ent = slots[head];
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  wb_entry_t [DEPTH-1:0] slots,
    input  logic [PW-1:0]         tail,
    input  logic [CW-1:0]         cnt,
    input  logic                  ld_valid,
    input  logic [ADDR_W-1:0]     ld_addr,
    output logic                  ld_hit,
    output logic                  ld_conflict,
    output logic [DATA_W-1:0]     ld_data
);
    logic      found;
    wb_entry_t pick;

    // Walk from oldest to newest; later (younger) matches overwrite older.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            logic [PW-1:0] idx;
            idx = PW'((int'(tail) + DEPTH - 1 - k) % DEPTH);
            if (k < int'(cnt) && slots[idx].addr[ADDR_W-1:2] == ld_addr[ADDR_W-1:2]) begin
                found = 1'b1;
                pick  = slots[idx];
            end
        end
    end

    always_comb begin
        ld_hit      = ld_valid && found && (pick.size == SZ_WORD);
        ld_conflict = ld_valid && found && (pick.size != SZ_WORD);
        ld_data     = ld_hit ? pick.data : '0;
    end
endmodule

// File: rtl/wbuf_drain_fsm.sv
module wbuf_drain_fsm
    import wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_data,
    input  logic rd_busy,
    input  logic ack,
    output logic req,
    output logic pop
);
    drain_st_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= DR_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            DR_IDLE: if (have_data && !rd_busy) st_nx = DR_SEND;
            DR_SEND: if (ack)                   st_nx = DR_IDLE;
            default:                            st_nx = DR_IDLE;
        endcase
    end

    always_comb begin
        req = 1'b0;
        pop = 1'b0;
        unique case (st)
            DR_IDLE: begin
                req = 1'b0;
                pop = 1'b0;
            end
            DR_SEND: begin
                req = 1'b1;
                pop = ack;
            end
            default: begin
                req = 1'b0;
                pop = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wbuf_write_buffer.sv
module wbuf_write_buffer
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [1:0]        st_size,
    output logic              st_ready,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic              ld_conflict,
    output logic [DATA_W-1:0] ld_data,
    input  logic              bus_rd_busy,
    output logic              drn_req,
    output logic [ADDR_W-1:0] drn_addr,
    output logic [DATA_W-1:0] drn_data,
    output logic [1:0]        drn_size,
    input  logic              drn_ack,
    output logic              full,
    output logic              empty
);
    wb_entry_t [DEPTH-1:0] slots;
    wb_entry_t             head_ent;
    wb_entry_t             new_ent;
    logic [PW-1:0]         tail;
    logic [CW-1:0]         cnt;
    logic                  push;
    logic                  pop;

    assign full     = (cnt == CW'(DEPTH));
    assign empty    = (cnt == '0);
    assign st_ready = !full;
    assign push     = st_valid && !full;
    assign new_ent  = '{addr: st_addr, data: st_data, size: st_size};

    wbuf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent (new_ent),
        .pop      (pop),
        .slots    (slots),
        .tail     (tail),
        .cnt      (cnt),
        .head_ent (head_ent)
    );

    wbuf_match #(.DEPTH(DEPTH)) u_match (
        .slots       (slots),
        .tail        (tail),
        .cnt         (cnt),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .ld_hit      (ld_hit),
        .ld_conflict (ld_conflict),
        .ld_data     (ld_data)
    );

    wbuf_drain_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_data (!empty),
        .rd_busy   (bus_rd_busy),
        .ack       (drn_ack),
        .req       (drn_req),
        .pop       (pop)
    );

    assign drn_addr = head_ent.addr;
    assign drn_data = head_ent.data;
    assign drn_size = head_ent.size;
endmodule

// File: rtl/wbuf_write_buffer_chk.sv
module wbuf_write_buffer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        st_valid,
    input logic        st_ready,
    input logic        ld_hit,
    input logic        ld_conflict,
    input logic [31:0] ld_data,
    input logic        bus_rd_busy,
    input logic        drn_req,
    input logic [17:0] drn_addr,
    input logic [31:0] drn_data,
    input logic        drn_ack,
    input logic        full,
    input logic        empty
);
    assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !st_ready);

    assert_req_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drn_req) |-> ($past(!bus_rd_busy) && $past(!empty)));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_req && !drn_ack) |=> (drn_req && $stable(drn_addr) && $stable(drn_data)));

    assert_no_req_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !drn_req);

    assert_swap_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && drn_req && drn_ack) |=> ($stable(full) && $stable(empty)));

    assert_hit_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_conflict));

    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_hit |-> (ld_data == 32'h0));
endmodule

bind wbuf_write_buffer wbuf_write_buffer_chk u_chk (.*);

// File: tb/wbuf_write_buffer_test.sv
module wbuf_write_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [17:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [1:0]  st_size = '0;
    logic        st_ready;
    logic        ld_valid = 1'b0;
    logic [17:0] ld_addr = '0;
    logic        ld_hit, ld_conflict;
    logic [31:0] ld_data;
    logic        bus_rd_busy = 1'b0;
    logic        drn_req;
    logic [17:0] drn_addr;
    logic [31:0] drn_data;
    logic [1:0]  drn_size;
    logic        drn_ack = 1'b0;
    logic        full, empty;

    int total = 0;
    int bad = 0;
    int swaps = 0;
    int fwd_hits = 0;
    int fwd_conf = 0;
    bit finished = 0;

    typedef struct {
        logic [17:0] a;
        logic [31:0] d;
        logic [1:0]  s;
    } ref_t;
    ref_t q[$];
    bit sending = 0;

    always #4 clk = ~clk;

    wbuf_write_buffer uut (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [17:0] pick_addr(input logic [1:0] sz);
        logic [17:0] base;
        logic [1:0]  off;
        base = 18'h00400 + 18'(($urandom % 4) * 4);
        off  = (sz == 2'b10) ? 2'b00 : (sz == 2'b01) ? {$urandom % 2 == 0, 1'b0} : 2'($urandom);
        return base | 18'(off);
    endfunction

    task automatic run(input int n, input int p_st, input int p_busy, input int p_ack, input int p_word);
        repeat (n) begin
            logic [1:0] sz;
            bit push, pop, nsend, found;
            ref_t y;
            @(negedge clk);
            st_valid    = ($urandom % 100) < p_st;
            sz          = (($urandom % 100) < p_word) ? 2'b10 : 2'($urandom % 2);
            st_size     = sz;
            st_addr     = pick_addr(sz);
            st_data     = $urandom;
            bus_rd_busy = ($urandom % 100) < p_busy;
            drn_ack     = ($urandom % 100) < p_ack;
            ld_valid    = ($urandom % 100) < 80;
            ld_addr     = pick_addr(2'($urandom % 3));
            #1;
            chk("R2 full", full, q.size() == 8);
            chk("R2 empty", empty, q.size() == 0);
            chk("R2/R3 st_ready", st_ready, q.size() < 8);
            chk("R5/R6/R7 drn_req", drn_req, sending);
            if (sending && q.size() > 0) begin
                chk("R4 drn_addr", drn_addr, q[0].a);
                chk("R4 drn_data", drn_data, q[0].d);
                chk("R4 drn_size", drn_size, q[0].s);
            end
            found = 0;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].a[17:2] == ld_addr[17:2]) begin
                    found = 1;
                    y = q[i];
                    break;
                end
            end
            if (ld_valid && found && y.s == 2'b10) begin
                fwd_hits++;
                chk("R9 ld_hit", ld_hit, 1);
                chk("R9 ld_data", ld_data, y.d);
                chk("R9 ld_conflict", ld_conflict, 0);
            end else if (ld_valid && found) begin
                fwd_conf++;
                chk("R10 ld_conflict", ld_conflict, 1);
                chk("R10 ld_hit", ld_hit, 0);
                chk("R10 ld_data", ld_data, 0);
            end else begin
                chk("R11 ld_hit", ld_hit, 0);
                chk("R11 ld_conflict", ld_conflict, 0);
                chk("R11 ld_data", ld_data, 0);
            end
            push  = st_valid && q.size() < 8;
            pop   = sending && drn_ack;
            nsend = sending ? !drn_ack : (q.size() > 0 && !bus_rd_busy);
            if (push && pop) swaps++;
            if (pop) void'(q.pop_front());
            if (push) q.push_back('{a: st_addr, d: st_data, s: st_size});
            sending = nsend;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 empty", empty, 1);
        chk("R1 full", full, 0);
        chk("R1 st_ready", st_ready, 1);
        chk("R1 drn_req", drn_req, 0);
        chk("R1 ld_hit", ld_hit, 0);
        chk("R1 ld_conflict", ld_conflict, 0);
        rst_n = 1'b1;
        // R3: bus busy, stores pile up past full and are dropped
        run(60, 90, 100, 50, 70);
        // R8: idle bus, heavy acks with steady stores
        run(600, 70, 0, 70, 60);
        // R7: stray acks while mostly busy
        run(400, 40, 70, 50, 50);
        run(600, 55, 30, 40, 80);
        // drain to empty
        run(100, 0, 0, 100, 50);
        chk("R8 enqueue with acknowledge seen", swaps > 0, 1);
        chk("R9 forwarding seen", fwd_hits > 0, 1);
        chk("R10 conflict seen", fwd_conf > 0, 1);
        chk("R4 drained to empty", empty, 1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule